// File: doc/BRIEF.md
# Transmit Process Control State Machine

This block sequences a DMA transmit engine that walks a ring of buffer descriptors. It holds the engine in one of four states: stopped, fetching a descriptor, running a frame, or suspended. It moves between them according to a software start bit, a poll-demand strobe, an automatic-poll enable, and handshakes from the descriptor fetcher and the MAC. Descriptor reads and the data path are outside the block. The block asks for a descriptor with a one-cycle request pulse and learns the ownership result through a done strobe.

When the fetched descriptor is still held by software, the engine does not stop. It raises a sticky "descriptor unavailable" flag and suspends. It leaves suspension through a fresh fetch, which is started by a poll demand or, with automatic polling enabled, by an internal interval timer. A jabber-timer expiry forces the engine to stop and raises a sticky flag. A finished frame whose first descriptor asked for an interrupt raises a sticky completion flag. Software clears any flag by writing 1 to its bit. When the start bit is cleared in the middle of a frame, that frame still completes, and the engine stops afterwards.

Top module: `tx_proc_ctrl`

## Requirements
- R1: After a synchronous reset, state_o is 0 (stopped), stopped_o is 1, sts_o is 0 and fetch_req is 0.
- R2: In the stopped state with start_en high, the next clock edge moves state_o to 1 (fetch), and fetch_req is high for exactly that one cycle.
- R3: In the fetch state, fetch_done with desc_own high moves state_o to 2 (run). In the run state, frame_end with start_en high moves state_o back to 1 and pulses fetch_req again.
- R4: In the fetch state, fetch_done with desc_own low sets sts_o bit 1 (descriptor unavailable) and moves state_o to 3 (suspended).
- R5: In the suspended state with autopoll_en low, the engine stays suspended and issues no fetch_req until poll_req is pulsed. The cycle after poll_req, state_o is 1 and fetch_req is high.
- R6: In the suspended state with autopoll_en high, the engine stays suspended for POLL_CYCLES clock edges after it enters suspension. On the POLL_CYCLES-th edge it moves to state 1 and pulses fetch_req.
- R7: jabber_expire in any state other than stopped moves state_o to 0 and sets sts_o bit 0 (jabber timeout). In the stopped state, jabber_expire has no effect on sts_o.
- R8: stopped_o is 1 exactly when state_o is 0.
- R9: sts_o bit 2 (transmit complete) is set by frame_end in the run state only when frame_ioc is high. A frame_end with frame_ioc low leaves the bit at 0.
- R10: sts_o bits stay at 1 until a cycle in which the same bit of sts_clr is 1. A 0 in sts_clr leaves the bit unchanged.
- R11: When a flag's set event and a 1 in its sts_clr bit occur in the same cycle, the flag is 1 afterwards.
- R12: Clearing start_en in the run state leaves state_o at 2 until frame_end, after which state_o is 0. Clearing start_en in the fetch or suspended state gives state_o 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Software start bit: 1 starts the engine, 0 stops it |
| poll_req | input | 1 | Poll-demand strobe |
| autopoll_en | input | 1 | Enables the automatic poll while suspended |
| fetch_done | input | 1 | Descriptor fetch result is valid |
| desc_own | input | 1 | Fetched descriptor is owned by the engine (valid with fetch_done) |
| jabber_expire | input | 1 | Transmit jabber timer expiry pulse |
| frame_end | input | 1 | Frame transmission finished |
| frame_ioc | input | 1 | Interrupt-on-completion flag of the frame's first descriptor (valid with frame_end) |
| sts_clr | input | 3 | Write-1-to-clear mask, same bit order as sts_o |
| fetch_req | output | 1 | One-cycle request for the next descriptor |
| state_o | output | 2 | Current state: 0 stopped, 1 fetch, 2 run, 3 suspended |
| stopped_o | output | 1 | Process-stopped status |
| sts_o | output | 3 | Sticky flags: bit 0 jabber, bit 1 descriptor unavailable, bit 2 complete |

## Verification
The assertions assume that fetch_done arrives only while a fetch is outstanding and that frame_end arrives only while a frame is running. Those strobes are ignored in other states, so the properties do not depend on them there. The bench raises fetch_done only after it has seen fetch_req and raises frame_end only after it has seen the run state. It drives every strobe for a single cycle, away from the clock edge. Jabber expiry is also pulsed in the stopped state, to show that it is ignored there.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    TPC_STOP  = 2'd0,
    TPC_FETCH = 2'd1,
    TPC_RUN   = 2'd2,
    TPC_SUSP  = 2'd3
  } tpc_state_e;

  localparam int unsigned STS_W    = 3;
  localparam int unsigned STS_JAB  = 0;
  localparam int unsigned STS_UNAV = 1;
  localparam int unsigned STS_DONE = 2;

endpackage

// File: rtl/tpc_poll_timer.sv
module tpc_poll_timer #(
  parameter int unsigned POLL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(POLL_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(POLL_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R6: the interval counter never passes its limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(POLL_CYCLES));

endmodule

// File: rtl/tpc_status.sv
module tpc_status #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts_q
);

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         sts_q[i] <= 1'b0;
      else if (set[i]) sts_q[i] <= 1'b1;
      else if (clr[i]) sts_q[i] <= 1'b0;
    end

    // R10: a flag holds unless its clear bit is written
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      (sts_q[i] && !clr[i]) |=> sts_q[i]);

    // R11: a set event is never lost to a simultaneous clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> sts_q[i]);
  end

endmodule

// File: rtl/tpc_fsm.sv
module tpc_fsm
  import tpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_en,
  input  logic             poll_req,
  input  logic             autopoll_en,
  input  logic             poll_tick,
  input  logic             fetch_done,
  input  logic             desc_own,
  input  logic             jabber,
  input  logic             frame_end,
  input  logic             frame_ioc,
  output tpc_state_e       state_q,
  output logic             stopped_q,
  output logic             fetch_req_q,
  output logic             poll_run,
  output logic [STS_W-1:0] set_flags
);

  tpc_state_e nxt;

  assign poll_run = (state_q == TPC_SUSP) && autopoll_en;

  always_comb begin
    nxt       = state_q;
    set_flags = '0;
    unique case (state_q)
      TPC_STOP: begin
        if (start_en) nxt = TPC_FETCH;
      end
      TPC_FETCH: begin
        if (!start_en) nxt = TPC_STOP;
        else if (fetch_done) begin
          if (desc_own) nxt = TPC_RUN;
          else begin
            nxt                 = TPC_SUSP;
            set_flags[STS_UNAV] = 1'b1;
          end
        end
      end
      TPC_RUN: begin
        if (frame_end) begin
          if (frame_ioc) set_flags[STS_DONE] = 1'b1;
          nxt = start_en ? TPC_FETCH : TPC_STOP;
        end
      end
      TPC_SUSP: begin
        if (!start_en) nxt = TPC_STOP;
        else if (poll_req || poll_tick) nxt = TPC_FETCH;
      end
      default: nxt = TPC_STOP;
    endcase
    if (jabber && (state_q != TPC_STOP)) begin
      nxt                = TPC_STOP;
      set_flags[STS_JAB] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= TPC_STOP;
      stopped_q   <= 1'b1;
      fetch_req_q <= 1'b0;
    end else begin
      state_q     <= nxt;
      stopped_q   <= (nxt == TPC_STOP);
      fetch_req_q <= (nxt == TPC_FETCH) && (state_q != TPC_FETCH);
    end
  end

  // R4: an unowned descriptor suspends the engine
  a_r4_unowned_suspends: assert property (@(posedge clk) disable iff (rst)
    (state_q == TPC_FETCH && start_en && fetch_done && !desc_own && !jabber)
    |=> (state_q == TPC_SUSP));

  // R7: jabber expiry stops an active engine
  a_r7_jabber_stops: assert property (@(posedge clk) disable iff (rst)
    (state_q != TPC_STOP && jabber) |=> (state_q == TPC_STOP && stopped_q));

  // R12: a frame in progress is never cut short by the start bit
  a_r12_frame_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == TPC_RUN && !frame_end && !jabber) |=> (state_q == TPC_RUN));

  // R5: without automatic polling, suspension waits for a poll demand
  a_r5_susp_waits: assert property (@(posedge clk) disable iff (rst)
    (state_q == TPC_SUSP && start_en && !autopoll_en && !poll_req && !jabber)
    |=> (state_q == TPC_SUSP && !fetch_req_q));

  // R2: a fetch request only accompanies the fetch state
  a_r2_req_in_fetch: assert property (@(posedge clk) disable iff (rst)
    fetch_req_q |-> (state_q == TPC_FETCH));

endmodule

// File: rtl/tx_proc_ctrl.sv
module tx_proc_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_en,
  input  logic       poll_req,
  input  logic       autopoll_en,
  input  logic       fetch_done,
  input  logic       desc_own,
  input  logic       jabber_expire,
  input  logic       frame_end,
  input  logic       frame_ioc,
  input  logic [2:0] sts_clr,
  output logic       fetch_req,
  output logic [1:0] state_o,
  output logic       stopped_o,
  output logic [2:0] sts_o
);

  tpc_state_e       state_q;
  logic             poll_run;
  logic             poll_tick;
  logic [STS_W-1:0] set_flags;

  tpc_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (poll_run),
    .tick (poll_tick)
  );

  tpc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_en    (start_en),
    .poll_req    (poll_req),
    .autopoll_en (autopoll_en),
    .poll_tick   (poll_tick),
    .fetch_done  (fetch_done),
    .desc_own    (desc_own),
    .jabber      (jabber_expire),
    .frame_end   (frame_end),
    .frame_ioc   (frame_ioc),
    .state_q     (state_q),
    .stopped_q   (stopped_o),
    .fetch_req_q (fetch_req),
    .poll_run    (poll_run),
    .set_flags   (set_flags)
  );

  tpc_status #(.W(STS_W)) u_status (
    .clk   (clk),
    .rst   (rst),
    .set   (set_flags),
    .clr   (sts_clr),
    .sts_q (sts_o)
  );

  assign state_o = state_q;

  // R8: the stopped status tracks the stopped state
  a_r8_stopped_match: assert property (@(posedge clk) disable iff (rst)
    stopped_o == (state_o == 2'd0));

endmodule

// File: tb/tx_proc_ctrl_tb.sv
`timescale 1ns/1ps
module tx_proc_ctrl_tb;

  localparam int unsigned POLL = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_en = 0, poll_req = 0, autopoll_en = 0;
  logic       fetch_done = 0, desc_own = 0, jabber_expire = 0;
  logic       frame_end = 0, frame_ioc = 0;
  logic [2:0] sts_clr = 0;
  logic       fetch_req, stopped_o;
  logic [1:0] state_o;
  logic [2:0] sts_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_proc_ctrl #(.POLL_CYCLES(POLL)) u_dut (
    .clk(clk), .rst(rst), .start_en(start_en), .poll_req(poll_req),
    .autopoll_en(autopoll_en), .fetch_done(fetch_done), .desc_own(desc_own),
    .jabber_expire(jabber_expire), .frame_end(frame_end), .frame_ioc(frame_ioc),
    .sts_clr(sts_clr), .fetch_req(fetch_req), .state_o(state_o),
    .stopped_o(stopped_o), .sts_o(sts_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one-cycle pulse helpers: drive at negedge, observe at the next negedge
  task automatic do_fetch(logic own);
    fetch_done = 1; desc_own = own; cyc(); fetch_done = 0; desc_own = 0;
  endtask

  task automatic do_frame(logic ioc);
    frame_end = 1; frame_ioc = ioc; cyc(); frame_end = 0; frame_ioc = 0;
  endtask

  task automatic t_reset();
    chk("R1", "state", state_o, 0);
    chk("R1", "stopped", stopped_o, 1);
    chk("R8", "stopped", stopped_o, 1);
    chk("R1", "sts", sts_o, 0);
    chk("R1", "fetch_req", fetch_req, 0);
  endtask

  task automatic t_start();
    start_en = 1; cyc();
    chk("R2", "state", state_o, 1);
    chk("R2", "fetch_req", fetch_req, 1);
    chk("R8", "stopped", stopped_o, 0);
    cyc();
    chk("R2", "fetch_req one cycle", fetch_req, 0);
    chk("R2", "state hold", state_o, 1);
  endtask

  task automatic t_run_chain();
    do_fetch(1);
    chk("R3", "run", state_o, 2);
    do_frame(0);
    chk("R3", "refetch", state_o, 1);
    chk("R3", "fetch_req", fetch_req, 1);
    chk("R9", "no ioc", sts_o[2], 0);
    do_fetch(1);
    do_frame(1);
    chk("R9", "ioc set", sts_o[2], 1);
  endtask

  task automatic t_clear();
    sts_clr = 3'b011; cyc(); sts_clr = 0;
    chk("R10", "other bits", sts_o[2], 1);
    cyc();
    chk("R10", "holds", sts_o[2], 1);
    sts_clr = 3'b100; cyc(); sts_clr = 0;
    chk("R10", "cleared", sts_o, 0);
  endtask

  task automatic t_suspend();
    logic seen;
    do_fetch(0);
    chk("R4", "susp", state_o, 3);
    chk("R4", "unav", sts_o[1], 1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (fetch_req || state_o != 3) seen = 1;
    end
    chk("R5", "waits", seen, 0);
    poll_req = 1; cyc(); poll_req = 0;
    chk("R5", "resume", state_o, 1);
    chk("R5", "fetch_req", fetch_req, 1);
    do_fetch(1);
    chk("R3", "run", state_o, 2);
  endtask

  task automatic t_autopoll();
    logic early;
    autopoll_en = 1;
    do_frame(0);
    do_fetch(0);
    chk("R6", "susp", state_o, 3);
    early = 0;
    for (int i = 1; i < POLL; i++) begin
      cyc();
      if (state_o != 3 || fetch_req) early = 1;
    end
    chk("R6", "no early poll", early, 0);
    cyc();
    chk("R6", "polled", state_o, 1);
    chk("R6", "fetch_req", fetch_req, 1);
    autopoll_en = 0;
    do_fetch(1);
    chk("R6", "run", state_o, 2);
    sts_clr = 3'b111; cyc(); sts_clr = 0;
  endtask

  task automatic t_stop_in_frame();
    start_en = 0;
    repeat (5) cyc();
    chk("R12", "frame holds", state_o, 2);
    do_frame(0);
    chk("R12", "stopped", state_o, 0);
    chk("R8", "stopped", stopped_o, 1);
    chk("R12", "no fetch", fetch_req, 0);
  endtask

  task automatic t_stop_in_susp();
    start_en = 1; cyc();
    do_fetch(0);
    chk("R4", "susp again", state_o, 3);
    start_en = 0; cyc();
    chk("R12", "susp stop", state_o, 0);
    start_en = 1; cyc();
    start_en = 0; cyc();
    chk("R12", "fetch stop", state_o, 0);
    sts_clr = 3'b111; cyc(); sts_clr = 0;
  endtask

  task automatic t_jabber();
    jabber_expire = 1; cyc(); jabber_expire = 0;
    chk("R7", "ignored when stopped", sts_o, 0);
    start_en = 1; cyc();
    do_fetch(1);
    jabber_expire = 1; start_en = 0; cyc(); jabber_expire = 0;
    chk("R7", "stopped", state_o, 0);
    chk("R7", "flag", sts_o[0], 1);
    chk("R8", "stopped", stopped_o, 1);
  endtask

  task automatic t_set_wins();
    sts_clr = 3'b001; cyc(); sts_clr = 0;
    chk("R10", "jab cleared", sts_o[0], 0);
    start_en = 1; cyc();
    do_fetch(1);
    frame_end = 1; frame_ioc = 1; sts_clr = 3'b100; cyc();
    frame_end = 0; frame_ioc = 0; sts_clr = 0;
    chk("R11", "set beats clear", sts_o[2], 1);
    sts_clr = 3'b100; cyc(); sts_clr = 0;
    chk("R10", "later clear", sts_o[2], 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_start();
    t_run_chain();
    t_clear();
    t_suspend();
    t_autopoll();
    t_stop_in_frame();
    t_stop_in_susp();
    t_jabber();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule